// File: doc/BRIEF.md
# Prescaled Compare Timer Channel

This block is one timer channel driven by a slow time-base tick, nominally 32.768 kHz, presented as a one-cycle enable pulse `tick_in` in the system clock domain. A power-of-two prescaler thins that tick stream. Each surviving tick advances a 16-bit up-counter, and the counter is compared with two compare registers. A match on either compare can latch a sticky flag, and the flags can drive a single interrupt request.

Software reaches the channel through a four-word register port with a write strobe, an address and a combinational read path. The setup word holds the prescale exponent, one two-bit event mode field per comparator, the counter enable, both match flags and a lock bit. The exponent and mode fields can be written only once after reset. The first setup write therefore claims the channel. Later writes can still start or stop the counter and clear flags. The usual restart sequence is three writes: the compare B value, then zero to the counter, then the enable bit together with the flag B clear bit.

Top module: `prescaled_timer_channel`

## Requirements
- R1: After reset every register reads zero: compare A (address 0), compare B (address 1), counter (address 2) and setup (address 3). The lock bit is clear and `irq` is low.
- R2: While enabled, the counter advances once every 2^scale input ticks. Scale is setup bits 3:0, and values above 8 act as 8. Writing the counter register restarts the prescaler phase.
- R3: Setup bit 15 enables the counter. While it is clear, the counter and the prescaler hold their values whatever `tick_in` does.
- R4: Compare B is checked on each prescaled tick. When the count equals compare B, the next count is 0, so the period is compare B + 1 ticks. If bit 0 of the compare B mode field (setup bits 9:8) is set, flag B (setup bit 14) also sets.
- R5: Compare A is checked on each prescaled tick in the same way. When it matches, flag A (setup bit 13) sets if bit 0 of its mode field (setup bits 11:10) is set. A compare A match never resets the counter.
- R6: Writing 1 to setup bit 13 or 14 clears that flag. Writing 0 leaves it unchanged. A single setup write can clear both flags and disable the counter at once.
- R7: The first setup write after reset stores scale and both mode fields and sets the lock bit (setup bit 12, read-only). Later writes leave those fields unchanged until reset, but their enable and flag-clear bits still act.
- R8: `irq` is high exactly when some flag is set while bit 1 of its own mode field is set.
- R9: If a flag is cleared by a write in the same cycle that a match sets it, the flag ends up set.
- R10: The counter register can be read and written directly. Counting past 0xFFFF rolls over to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle pulse per time-base tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 compare A, 1 compare B, 2 counter, 3 setup |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong prescaler phase or counter value shows up as a wrong count on the next read of address 2. A wrong wrap point shows up as a flag that sets one prescaled tick early or late, visible at address 3 and, when the interrupt mode bit is set, on `irq` one clock after the matching tick. A lock that leaks shows up at once as changed scale or mode bits on the next setup read. A lost flag clear or set shows up on `irq` in the cycle after the write.

// File: rtl/prescaled_timer_channel.sv
module prescaled_timer_channel #(
  parameter int CNT_W     = 16,
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  localparam int PRE_W   = MAX_SCALE;
  localparam int B_EN    = 15;
  localparam int B_FLGB  = 14;
  localparam int B_FLGA  = 13;
  localparam int B_LOCK  = 12;
  localparam int B_MODEA = 10;
  localparam int B_MODEB = 8;

  localparam logic [1:0] A_CMPA = 2'd0;
  localparam logic [1:0] A_CMPB = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_SET  = 2'd3;

  logic [CNT_W-1:0]   cmp_a, cmp_b, cnt;
  logic [PRE_W-1:0]   pre_cnt, pre_mask;
  logic [SCALE_W-1:0] scale, eff_scale;
  logic [1:0]         mode_a, mode_b;
  logic               en, locked, flag_a, flag_b;

  logic wr_cmpa, wr_cmpb, wr_cnt, wr_set;
  logic fire, hit_a, hit_b, set_a, set_b, clr_a, clr_b;
  logic unused_wbits;

  assign wr_cmpa = reg_wr && (reg_addr == A_CMPA);
  assign wr_cmpb = reg_wr && (reg_addr == A_CMPB);
  assign wr_cnt  = reg_wr && (reg_addr == A_CNT);
  assign wr_set  = reg_wr && (reg_addr == A_SET);

  assign eff_scale = (int'(scale) > MAX_SCALE) ? SCALE_W'(MAX_SCALE) : scale;
  assign pre_mask  = ~({PRE_W{1'b1}} << eff_scale);
  assign fire      = en && tick_in && ((pre_cnt & pre_mask) == pre_mask);

  assign hit_a = fire && (cnt == cmp_a);
  assign hit_b = fire && (cnt == cmp_b);
  assign set_a = hit_a && mode_a[0];
  assign set_b = hit_b && mode_b[0];
  assign clr_a = wr_set && reg_wdata[B_FLGA];
  assign clr_b = wr_set && reg_wdata[B_FLGB];

  assign unused_wbits = ^{reg_wdata[7:SCALE_W], reg_wdata[B_LOCK]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= '0;
      cmp_b <= '0;
    end else begin
      if (wr_cmpa) cmp_a <= reg_wdata;
      if (wr_cmpb) cmp_b <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (wr_cnt) begin
      pre_cnt <= '0;
      cnt     <= reg_wdata;
    end else if (en && tick_in) begin
      pre_cnt <= pre_cnt + 1'b1;
      if (fire) cnt <= hit_b ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale  <= '0;
      mode_a <= '0;
      mode_b <= '0;
      locked <= 1'b0;
      en     <= 1'b0;
    end else if (wr_set) begin
      en <= reg_wdata[B_EN];
      if (!locked) begin
        scale  <= reg_wdata[SCALE_W-1:0];
        mode_a <= reg_wdata[B_MODEA+1:B_MODEA];
        mode_b <= reg_wdata[B_MODEB+1:B_MODEB];
        locked <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      flag_a <= set_a || (flag_a && !clr_a);
      flag_b <= set_b || (flag_b && !clr_b);
    end
  end

  assign irq = (flag_a && mode_a[1]) || (flag_b && mode_b[1]);

  logic [15:0] setup_word;
  assign setup_word = {en, flag_b, flag_a, locked, mode_a, mode_b,
                       {(8-SCALE_W){1'b0}}, scale};

  always_comb begin
    case (reg_addr)
      A_CMPA:  reg_rdata = cmp_a;
      A_CMPB:  reg_rdata = cmp_b;
      A_CNT:   reg_rdata = cnt;
      default: reg_rdata = CNT_W'(setup_word);
    endcase
  end

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_cnt) |=> $stable(cnt));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && !clr_b) |=> flag_b);

  // R7
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(scale) && $stable(mode_a) && $stable(mode_b) && locked));

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_a && !flag_b) |-> !irq);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_b && clr_b) |=> flag_b);

  // R4
  wrap_on_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && !wr_cnt) |=> (cnt == '0));
endmodule

// File: tb/prescaled_timer_channel_bench.sv
module prescaled_timer_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prescaled_timer_channel u_prescaled_timer_channel (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {scale[3:0], cmp_b[15:0], ticks[15:0], exp_cnt[15:0], exp_flag}
  localparam int NV = 8;
  localparam logic [52:0] VEC [NV] = '{
    {4'd0, 16'd20,     16'd10,   16'd10, 1'b0},
    {4'd0, 16'd20,     16'd21,   16'd0,  1'b1},
    {4'd2, 16'd5,      16'd30,   16'd1,  1'b1},
    {4'd3, 16'd100,    16'd47,   16'd5,  1'b0},
    {4'd8, 16'd3,      16'd1024, 16'd0,  1'b1},
    {4'd4, 16'd15,     16'd255,  16'd15, 1'b0},
    {4'd1, 16'hFFFE,   16'd40,   16'd20, 1'b0},
    {4'd0, 16'd9,      16'd30,   16'd0,  1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick_in = 1'b0;
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b1;
      @(negedge clk);
    end
    tick_in = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", v, 16'h0000);
    end
    check("R1 reset irq", {15'd0, irq}, 16'd0);

    // R2/R4 table: prescaled counting, wrap at compare B, flag B and irq
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd1, VEC[i][48:33]);
      wr(2'd2, 16'h0000);
      wr(2'd3, 16'h8300 | {12'd0, VEC[i][52:49]});
      ticks(int'(VEC[i][32:17]));
      rd(2'd2, v);
      check("R2 count after ticks", v, VEC[i][16:1]);
      rd(2'd3, v);
      check("R4 flag B", {15'd0, v[14]}, {15'd0, VEC[i][0]});
      check("R8 irq follows flag B", {15'd0, irq}, {15'd0, VEC[i][0]});
    end

    // R2 scale above 8 acts as 8
    do_reset();
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h800C);
    ticks(512);
    rd(2'd2, v);
    check("R2 scale clamp", v, 16'd2);

    // R2 counter write restarts prescaler phase
    do_reset();
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h8002);
    ticks(3);
    wr(2'd2, 16'h0000);
    ticks(3);
    rd(2'd2, v);
    check("R2 prescaler restart", v, 16'd0);
    ticks(1);
    rd(2'd2, v);
    check("R2 prescaler restart step", v, 16'd1);

    // R5 compare A flags without wrapping; R4 wrap at B
    do_reset();
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd10);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h8D00);
    ticks(5);
    rd(2'd2, v);
    check("R5 no wrap at compare A", v, 16'd5);
    rd(2'd3, v);
    check("R5 flag A set", {15'd0, v[13]}, 16'd1);
    check("R8 irq from flag A", {15'd0, irq}, 16'd1);
    ticks(7);
    rd(2'd2, v);
    check("R4 wrap at compare B", v, 16'd1);
    rd(2'd3, v);
    check("R4 flag B set mode 1", {15'd0, v[14]}, 16'd1);

    // R6 one write clears both flags and disables
    wr(2'd3, 16'h6000);
    rd(2'd3, v);
    check("R6 clear both and disable", v & 16'hE000, 16'h0000);
    check("R6 irq dropped", {15'd0, irq}, 16'd0);

    // R3 hold while disabled
    ticks(5);
    rd(2'd2, v);
    check("R3 hold when disabled", v, 16'd1);

    // R7 lock keeps scale and modes; enable still writable
    wr(2'd3, 16'h8005);
    rd(2'd3, v);
    check("R7 locked fields kept", v, 16'h9D00);

    // R6 writing zero to flags keeps them
    ticks(10);
    wr(2'd3, 16'h8000);
    rd(2'd3, v);
    check("R6 zero write keeps flags", v, 16'hFD00);
    rd(2'd2, v);
    check("R4 count after second wrap", v, 16'd0);

    // R4/R8 mode 2: no flag, no irq, still wraps
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h8200);
    ticks(5);
    rd(2'd2, v);
    check("R4 wrap with mode 2", v, 16'd2);
    rd(2'd3, v);
    check("R4 mode 2 no flag", {15'd0, v[14]}, 16'd0);
    check("R8 mode 2 no irq", {15'd0, irq}, 16'd0);

    // R8 mode 1: flag without irq
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h8100);
    ticks(5);
    rd(2'd3, v);
    check("R8 mode 1 flag", {15'd0, v[14]}, 16'd1);
    check("R8 mode 1 no irq", {15'd0, irq}, 16'd0);

    // R10 direct counter access and rollover
    do_reset();
    wr(2'd2, 16'h1234);
    rd(2'd2, v);
    check("R10 counter write", v, 16'h1234);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'hFFFE);
    wr(2'd3, 16'h8300);
    ticks(3);
    rd(2'd2, v);
    check("R10 rollover", v, 16'd1);
    rd(2'd3, v);
    check("R10 rollover no flag", {15'd0, v[14]}, 16'd0);

    // R9 set and clear in the same cycle
    do_reset();
    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h8300);
    tick_in = 1'b1;
    reg_wr = 1'b1;
    reg_addr = 2'd3;
    reg_wdata = 16'hC000;
    @(negedge clk);
    tick_in = 1'b0;
    reg_wr = 1'b0;
    rd(2'd3, v);
    check("R9 set wins over clear", {15'd0, v[14]}, 16'd1);
    check("R9 irq after collision", {15'd0, irq}, 16'd1);

    finish_run();
  end
endmodule